// File: doc/BRIEF.md
# Multiplexed-Address DRAM Strobe Controller with Refresh

This block sits between a simple on-chip requester and an asynchronous dynamic memory. The memory has a shared address bus and active-low row strobe, column strobe and write-enable pins. The host side accepts one read or write at a time through a valid/ready handshake. The request carries a flat address, a write flag and a data word. One response pulse is returned for each accepted request. It carries the read word, or it marks that a write has completed.

The flat address is split into an upper row part and a lower column part. The row goes onto the shared pins one cycle before the row strobe falls. The column goes out with the column strobe. The row remains open after an access. A later request to that row is served by a column strobe pulse alone, which is page mode. A request to any other row closes the row first. Every phase length is a parameter given in clock cycles: row-to-column delay, column strobe width, precharge, and refresh strobe width.

A free-running interval timer raises a refresh request. While that request is pending, new host requests are held off. The current access is allowed to finish. Any open row is then closed and precharged. A refresh cycle follows in which the column strobe falls before the row strobe, so the memory uses its own internal row counter.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: After reset, and whenever no row is open and no refresh is running, the row strobe, column strobe and write enable are all high (inactive), and `req_ready` is high unless a refresh is pending.
- R2: The row is `req_addr[ROW_W+COL_W-1:COL_W]` and the column is `req_addr[COL_W-1:0]`. The row is on `dram_addr` in the cycle before the row strobe falls and holds through the fall. The column is on `dram_addr` when the column strobe falls for a host access.
- R3: For a host access, the column strobe falls at least `T_RCD` cycles after the row strobe fell. Write enable is low only while both strobes are low, and only for a write.
- R4: The column strobe is always high before the row strobe rises. The row strobe stays high for at least `T_RP` cycles before it falls again, and before a refresh column strobe falls.
- R5: Read data is sampled from `dram_rdata` on the last of the `T_CAS` column-strobe cycles. It is returned with a one-cycle `rsp_valid` pulse and `rsp_write` = 0. A write completes with a pulse and `rsp_write` = 1.
- R6: A request to the open row is accepted without a new row strobe fall (page hit). A request to a different row closes the row and reopens it with a new row strobe fall.
- R7: A refresh is requested every `REFI_CYC` cycles. It is a column-strobe-before-row-strobe cycle: the column strobe falls while the row strobe is high, and the row strobe falls on the next cycle.
- R8: A pending refresh holds `req_ready` low. It waits for the current access to finish and never cuts one short. It closes an open row and is served within a bounded number of cycles. No host request is accepted while the refresh runs.
- R9: Exactly one response is returned per accepted request, in acceptance order, with no second request accepted before the previous one has responded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Flat word address (row high, column low) |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_write | output | 1 | Completion belongs to a write |
| rsp_rdata | output | DATA_W | Read data, valid with a read completion |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_wdata | output | DATA_W | Data driven to the memory |
| dram_rdata | input | DATA_W | Data returned by the memory |

## Verification
The bench surrounds the controller with a behavioural memory that decodes the strobes. On every edge it measures the row-high and row-low intervals and the refresh spacing. A design with an off-by-one precharge or row-to-column count would trip these measurements. So would a design that lets a refresh wait behind a page burst. Long same-row bursts are mixed with row misses and idle stretches that leave a row open. A controller that reissued the row strobe on a hit, kept a stale row after a miss, or never closed an idle row for refresh would then show wrong activation counts, wrong read data or a refresh-gap violation. Reads at the lowest and highest address and reads right after writes in the same page catch swapped row/column halves and a mistimed data sample.

// File: rtl/dram_ctrl_pkg.sv
// Shared state encoding and strobe decode for the DRAM strobe controller.
// Assumes: all consumers compile this package first.
package dram_ctrl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,   // nothing open, strobes high
        ST_SETUP,  // row on pins, row strobe still high
        ST_RCD,    // row strobe low, waiting row-to-column delay
        ST_CAS,    // column strobe low, access in flight
        ST_OPEN,   // row held open, column strobe high
        ST_PRE,    // precharge, all strobes high
        ST_RCBR,   // refresh: column strobe low first
        ST_RACT,   // refresh: both strobes low
        ST_RREL    // refresh: column strobe released, row still low
    } seq_state_t;

    // Row strobe is active in these states.
    function automatic logic ras_active(input seq_state_t s);
        return (s == ST_RCD) || (s == ST_CAS) || (s == ST_OPEN) ||
               (s == ST_RACT) || (s == ST_RREL);
    endfunction

    // Column strobe is active in these states.
    function automatic logic cas_active(input seq_state_t s);
        return (s == ST_CAS) || (s == ST_RCBR) || (s == ST_RACT);
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
// Refresh interval timer: raises a sticky request every REFI_CYC cycles,
// cleared when the sequencer starts the refresh.
// Assumes: one refresh completes well within one interval.
module dram_refresh_timer #(
    parameter int REFI_CYC = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ack,
    output logic ref_pend
);
    localparam int TW = $clog2(REFI_CYC + 1);
    localparam logic [TW-1:0] RELOAD = TW'(REFI_CYC - 1);

    logic [TW-1:0] tick_q;
    logic          pend_q;

    // Count down the interval and hold the request until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= RELOAD;
            pend_q <= 1'b0;
        end else begin
            tick_q <= (tick_q == '0) ? RELOAD : tick_q - 1'b1;
            if (tick_q == '0)
                pend_q <= 1'b1;
            else if (ref_ack)
                pend_q <= 1'b0;
        end
    end

    assign ref_pend = pend_q;

    // R7
    ack_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> pend_q);

endmodule

// File: rtl/dram_addr_mux.sv
// Registered row/column multiplexer for the shared address pins.
// Assumes: sel_col and the row/column inputs are next-cycle values.
module dram_addr_mux #(
    parameter int ROW_W = 10,
    parameter int COL_W = 10
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        sel_col,
    input  logic [ROW_W-1:0]                            row_in,
    input  logic [COL_W-1:0]                            col_in,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] addr_out
);
    localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W;

    logic [MA_W-1:0] row_ext;
    logic [MA_W-1:0] col_ext;

    // Zero-extend both halves to the pin width.
    always_comb begin
        row_ext = '0;
        col_ext = '0;
        row_ext[ROW_W-1:0] = row_in;
        col_ext[COL_W-1:0] = col_in;
    end

    // Register the selected half so the pins switch with the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_out <= '0;
        else        addr_out <= sel_col ? col_ext : row_ext;
    end

endmodule

// File: rtl/dram_seq_fsm.sv
// Strobe sequencer: accepts host requests, walks the row/column/precharge
// phases, keeps a row open for page hits and runs refresh cycles in which
// the column strobe leads. Strobe outputs are registered from the next state.
// Assumes: all T_* parameters are at least 1.
module dram_seq_fsm
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W     = 10,
    parameter int COL_W     = 10,
    parameter int DATA_W    = 16,
    parameter int T_RCD     = 3,
    parameter int T_CAS     = 2,
    parameter int T_RP      = 3,
    parameter int T_REF_RAS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ref_pend,
    output logic                    ref_ack,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [ROW_W+COL_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic                    ras_n,
    output logic                    cas_n,
    output logic                    we_n,
    output logic [DATA_W-1:0]       mem_wdata,
    output logic                    sel_col_d,
    output logic [ROW_W-1:0]        row_d,
    output logic [COL_W-1:0]        col_d,
    output logic                    rsp_valid,
    output logic                    rsp_write,
    output logic [DATA_W-1:0]       rsp_rdata
);
    localparam int AW    = ROW_W + COL_W;
    localparam int MAX_T = max4(T_RCD, T_CAS, T_RP, T_REF_RAS);
    localparam int CNT_W = (MAX_T < 2) ? 1 : $clog2(MAX_T);
    localparam logic [CNT_W-1:0] L_RCD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] L_CAS = CNT_W'(T_CAS - 1);
    localparam logic [CNT_W-1:0] L_RP  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] L_REF = CNT_W'(T_REF_RAS - 1);

    seq_state_t        st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [AW-1:0]     lat_addr_q, lat_addr_d;
    logic              lat_wr_q, lat_wr_d;
    logic [DATA_W-1:0] lat_wdata_q, lat_wdata_d;
    logic              hit, acc, cnt_zero, access_done;

    // Handshake: idle takes any request, an open row takes only hits.
    always_comb begin
        hit       = (st_q == ST_OPEN) && (req_addr[AW-1:COL_W] == lat_addr_q[AW-1:COL_W]);
        req_ready = !ref_pend && ((st_q == ST_IDLE) || hit);
        acc       = req_valid && req_ready;
        ref_ack   = (st_q == ST_IDLE) && ref_pend;
        cnt_zero  = (cnt_q == '0);
        access_done = (st_q == ST_CAS) && cnt_zero;
    end

    // Next-state and phase counter.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_zero ? cnt_q : cnt_q - 1'b1;
        unique case (st_q)
            ST_IDLE:  if (ref_pend)       st_d = ST_RCBR;
                      else if (req_valid) st_d = ST_SETUP;
            ST_SETUP: begin st_d = ST_RCD; cnt_d = L_RCD; end
            ST_RCD:   if (cnt_zero) begin st_d = ST_CAS; cnt_d = L_CAS; end
            ST_CAS:   if (cnt_zero) st_d = ST_OPEN;
            ST_OPEN:  if (ref_pend || (req_valid && !hit)) begin
                          st_d = ST_PRE; cnt_d = L_RP;
                      end else if (acc) begin
                          st_d = ST_CAS; cnt_d = L_CAS;
                      end
            ST_PRE:   if (cnt_zero) st_d = ST_IDLE;
            ST_RCBR:  begin st_d = ST_RACT; cnt_d = L_REF; end
            ST_RACT:  if (cnt_zero) st_d = ST_RREL;
            ST_RREL:  begin st_d = ST_PRE; cnt_d = L_RP; end
            default:  st_d = ST_IDLE;
        endcase
    end

    // Request latch update and next-cycle address selection.
    always_comb begin
        lat_addr_d  = acc ? req_addr  : lat_addr_q;
        lat_wr_d    = acc ? req_write : lat_wr_q;
        lat_wdata_d = acc ? req_wdata : lat_wdata_q;
        row_d       = lat_addr_d[AW-1:COL_W];
        col_d       = lat_addr_d[COL_W-1:0];
        sel_col_d   = (st_d == ST_CAS) || (st_d == ST_OPEN);
    end

    // State, request latch and registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            cnt_q       <= '0;
            lat_addr_q  <= '0;
            lat_wr_q    <= 1'b0;
            lat_wdata_q <= '0;
            ras_n       <= 1'b1;
            cas_n       <= 1'b1;
            we_n        <= 1'b1;
        end else begin
            st_q        <= st_d;
            cnt_q       <= cnt_d;
            lat_addr_q  <= lat_addr_d;
            lat_wr_q    <= lat_wr_d;
            lat_wdata_q <= lat_wdata_d;
            ras_n       <= !ras_active(st_d);
            cas_n       <= !cas_active(st_d);
            we_n        <= !((st_d == ST_CAS) && lat_wr_d);
        end
    end

    // Completion pulse and read-data capture at the end of the column phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_write <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= access_done;
            if (access_done) begin
                rsp_write <= lat_wr_q;
                if (!lat_wr_q) rsp_rdata <= mem_rdata;
            end
        end
    end

    assign mem_wdata = lat_wdata_q;

    // R6
    page_hit_no_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OPEN && acc) |=> (!ras_n && $past(!ras_n)));

    // R5
    wr_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_write) |-> $past(!we_n));

    // R5
    rd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_write) |-> $past(we_n));

endmodule

// File: rtl/dram_strobe_ctrl.sv
// Top of the DRAM strobe controller: refresh timer, sequencer and address
// multiplexer. Checker counters below exist only for the assertions.
// Assumes: a single-rank memory with separate data in/out and an internal
// refresh row counter.
module dram_strobe_ctrl #(
    parameter int ROW_W     = 10,
    parameter int COL_W     = 10,
    parameter int DATA_W    = 16,
    parameter int T_RCD     = 3,
    parameter int T_CAS     = 2,
    parameter int T_RP      = 3,
    parameter int T_REF_RAS = 4,
    parameter int REFI_CYC  = 1562
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          req_valid,
    output logic                                          req_ready,
    input  logic                                          req_write,
    input  logic [ROW_W+COL_W-1:0]                        req_addr,
    input  logic [DATA_W-1:0]                             req_wdata,
    output logic                                          rsp_valid,
    output logic                                          rsp_write,
    output logic [DATA_W-1:0]                             rsp_rdata,
    output logic                                          dram_ras_n,
    output logic                                          dram_cas_n,
    output logic                                          dram_we_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0]  dram_addr,
    output logic [DATA_W-1:0]                             dram_wdata,
    input  logic [DATA_W-1:0]                             dram_rdata
);
    localparam int WAIT_MAX = T_RCD + T_CAS + T_RP + 4;

    logic             ref_pend, ref_ack, sel_col_d;
    logic [ROW_W-1:0] row_d;
    logic [COL_W-1:0] col_d;

    dram_refresh_timer #(.REFI_CYC(REFI_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .ref_pend(ref_pend)
    );

    dram_seq_fsm #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_REF_RAS(T_REF_RAS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .ref_pend(ref_pend), .ref_ack(ref_ack),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_rdata(dram_rdata),
        .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
        .mem_wdata(dram_wdata), .sel_col_d(sel_col_d), .row_d(row_d), .col_d(col_d),
        .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_rdata(rsp_rdata)
    );

    dram_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_amux (
        .clk(clk), .rst_n(rst_n), .sel_col(sel_col_d),
        .row_in(row_d), .col_in(col_d), .addr_out(dram_addr)
    );

    // ---------------- checker state (assertions only) ----------------
    logic [7:0] hi_cnt, lo_cnt, wait_cnt;
    logic       outs_q;

    // Measure row-high, row-low and refresh-wait runs, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt   <= 8'hFF;
            lo_cnt   <= '0;
            wait_cnt <= '0;
        end else begin
            hi_cnt   <= !dram_ras_n ? 8'd0 : ((hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 8'd1);
            lo_cnt   <= dram_ras_n  ? 8'd0 : ((lo_cnt == 8'hFF) ? lo_cnt : lo_cnt + 8'd1);
            wait_cnt <= !ref_pend   ? 8'd0 : ((wait_cnt == 8'hFF) ? wait_cnt : wait_cnt + 8'd1);
        end
    end

    // Track whether an accepted request still owes a response.
    always_ff @(posedge clk) begin
        if (!rst_n)                      outs_q <= 1'b0;
        else if (req_valid && req_ready) outs_q <= 1'b1;
        else if (rsp_valid)              outs_q <= 1'b0;
    end

    // R2
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && dram_cas_n) |-> $stable(dram_addr));

    // R3
    rcd_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_ras_n) |-> (lo_cnt >= T_RCD));

    // R3
    we_in_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> (!dram_cas_n && !dram_ras_n));

    // R4
    cas_first_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> (dram_cas_n && $past(dram_cas_n)));

    // R4
    precharge_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) || ($fell(dram_cas_n) && dram_ras_n)) |-> (hi_cnt >= T_RP));

    // R5
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7
    cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && dram_ras_n) |=> $fell(dram_ras_n));

    // R8
    ref_blocks_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pend |-> !req_ready);

    // R8
    ref_wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= WAIT_MAX);

    // R9
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (!outs_q || rsp_valid));

    // R9
    rsp_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> outs_q);

endmodule

// File: tb/dram_strobe_ctrl_tb.sv
`timescale 1ns/1ps
module dram_strobe_ctrl_tb_top;
    localparam int RW = 4, CW = 4, DW = 16, AW = RW + CW, NW = 1 << AW;
    localparam int TRCD = 2, TCAS = 2, TRP = 3, TREFRAS = 3, REFI = 150;
    localparam int WAIT_MAX = TRCD + TCAS + TRP + 4;
    localparam int GAP_MAX  = REFI + WAIT_MAX + 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, rsp_write;
    logic [DW-1:0] rsp_rdata, dram_wdata;
    logic [DW-1:0] dram_rdata = '0;
    logic dram_ras_n, dram_cas_n, dram_we_n;
    logic [RW-1:0] dram_addr;

    always #5 clk = ~clk;

    dram_strobe_ctrl #(.ROW_W(RW), .COL_W(CW), .DATA_W(DW), .T_RCD(TRCD), .T_CAS(TCAS),
                       .T_RP(TRP), .T_REF_RAS(TREFRAS), .REFI_CYC(REFI)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_rdata(rsp_rdata),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata));

    int n_chk = 0, n_fail = 0, n_acc = 0, n_rsp = 0;
    int act_cnt = 0, ref_cnt = 0, cyc = 0;
    logic [AW-1:0] cur_addr = '0;
    logic [DW-1:0] mem [NW];
    logic [DW-1:0] sh  [NW];
    bit            exp_wr_q [$];
    logic [DW-1:0] exp_d_q  [$];

    function automatic logic [DW-1:0] init_val(input int a);
        return DW'(a * 16'h0101) ^ 16'h5A3C;
    endfunction

    function automatic void chk(input bit ok, input string req, input string what,
                                input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endfunction

    // Behavioural memory: decodes strobes at the falling clock edge.
    bit prev_ras = 1'b1, prev_cas = 1'b1, in_ref = 1'b0;
    int hi = 1000, lo = 0, gap = 0;
    logic [RW-1:0] m_row = '0;
    logic [CW-1:0] m_col = '0;
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) mem[i] = init_val(i);
            prev_ras = 1'b1; prev_cas = 1'b1; hi = 1000; lo = 0; gap = 0; in_ref = 1'b0;
        end else begin
            cyc++; gap++;
            if (prev_cas && !dram_cas_n && dram_ras_n) begin
                chk(hi >= TRP, "R4", "precharge before refresh", hi, TRP);
                chk(gap <= GAP_MAX, "R7", "refresh spacing", gap, GAP_MAX);
                gap = 0; ref_cnt++; in_ref = 1'b1;
            end
            if (prev_ras && !dram_ras_n && dram_cas_n) begin
                chk(hi >= TRP, "R4", "precharge before activate", hi, TRP);
                chk(dram_addr == cur_addr[AW-1:CW], "R2", "row address", dram_addr, cur_addr[AW-1:CW]);
                m_row = dram_addr; act_cnt++;
            end
            if (prev_cas && !dram_cas_n && !dram_ras_n) begin
                chk(lo >= TRCD, "R3", "row to column delay", lo, TRCD);
                chk(dram_addr[CW-1:0] == cur_addr[CW-1:0], "R2", "column address",
                    dram_addr[CW-1:0], cur_addr[CW-1:0]);
                m_col = dram_addr[CW-1:0];
                if (!dram_we_n) mem[{m_row, m_col}] = dram_wdata;
            end
            if (!prev_ras && dram_ras_n) begin
                chk(prev_cas && dram_cas_n, "R4", "column released before row", dram_cas_n, 1);
                in_ref = 1'b0;
            end
            if (!dram_we_n) chk(!dram_cas_n && !dram_ras_n, "R3", "write enable outside column phase", dram_cas_n, 0);
            if (in_ref) chk(!req_ready, "R8", "ready during refresh", req_ready, 0);
            if (dram_ras_n) begin hi++; lo = 0; end else begin lo++; hi = 0; end
            dram_rdata = (!dram_ras_n && !dram_cas_n) ? mem[{m_row, m_col}] : 16'hDEAD;
            prev_ras = dram_ras_n; prev_cas = dram_cas_n;
        end
    end

    // Response scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_rsp++;
            if (exp_wr_q.size() == 0) chk(1'b0, "R9", "response without request", 1, 0);
            else begin
                automatic bit w = exp_wr_q.pop_front();
                automatic logic [DW-1:0] d = exp_d_q.pop_front();
                chk(rsp_write == w, "R9", "response order/kind", rsp_write, w);
                if (!w) chk(rsp_rdata == d, "R5", "read data", rsp_rdata, d);
            end
        end
    end

    // Issue one request and wait for acceptance; called at a falling edge.
    task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        cur_addr = a; n_acc++;
        if (wr) begin sh[a] = d; exp_wr_q.push_back(1'b1); exp_d_q.push_back('0); end
        else begin exp_wr_q.push_back(1'b0); exp_d_q.push_back(sh[a]); end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int a0, r0;
        logic [AW-1:0] prev_a;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NW; i++) sh[i] = init_val(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R1", "strobes idle after reset",
            {dram_ras_n, dram_cas_n, dram_we_n}, 7);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "no response after reset", rsp_valid, 0);

        // R5: extreme addresses, write then read back
        do_req(1'b0, '0, '0);
        do_req(1'b1, '1, 16'hBEEF);
        do_req(1'b0, '1, '0);
        do_req(1'b1, '0, 16'h1234);
        do_req(1'b0, '0, '0);
        idle(10);

        // R6: page burst on one row reuses the open row
        a0 = act_cnt; r0 = ref_cnt;
        for (int k = 0; k < 6; k++) do_req(k[0], {4'd5, 4'(k * 3)}, DW'(16'h7700 + k));
        idle(12);
        chk((act_cnt - a0) <= 1 + (ref_cnt - r0), "R6", "activations in page burst", act_cnt - a0, 1);

        // R6: a miss reopens with a new row strobe
        do_req(1'b1, {4'd2, 4'd9}, 16'hA5A5);
        a0 = act_cnt;
        do_req(1'b0, {4'd9, 4'd2}, '0);
        idle(10);
        chk((act_cnt - a0) >= 1, "R6", "activation on row miss", act_cnt - a0, 1);
        do_req(1'b0, {4'd2, 4'd9}, '0);

        // R8: row left open must be closed for refresh, then R1 idle state
        r0 = ref_cnt;
        while (ref_cnt == r0) @(negedge clk);
        idle(TREFRAS + TRP + 4);
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R8", "row closed after refresh",
            {dram_ras_n, dram_cas_n, dram_we_n}, 7);
        chk(req_ready == 1'b1, "R1", "ready when idle and closed", req_ready, 1);

        // Random mix with row locality
        prev_a = '0;
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            a = ($urandom_range(0, 9) < 6) ? {prev_a[AW-1:CW], CW'($urandom())} : AW'($urandom());
            do_req(($urandom_range(0, 1) == 1), a, DW'($urandom()));
            prev_a = a;
            if ($urandom_range(0, 7) == 0) idle($urandom_range(0, 6));
        end
        idle(20);

        // R9 and R7 end-of-run totals
        chk(n_rsp == n_acc, "R9", "responses per accepted request", n_rsp, n_acc);
        chk(exp_wr_q.size() == 0, "R9", "no response outstanding", exp_wr_q.size(), 0);
        chk(ref_cnt >= (cyc / REFI) - 1, "R7", "refresh count", ref_cnt, (cyc / REFI) - 1);
        summary();
        $finish;
    end
endmodule